// File: doc/BRIEF.md
# Four-way parallel Poly1305 accumulator

This block advances a Poly1305 accumulator over a run of 64-byte message chunks. Each chunk holds four 16-byte blocks. They are absorbed in one step using key powers prepared earlier: r, r squared, r cubed and r to the fourth, each held as five 26-bit limbs. Every block receives its 2^128 pad bit. The limbs of all four blocks are multiplied against the matching key power, and the twenty-five partial products per block are summed into five 64-bit column sums. A single carry pass then leaves a partially reduced five-limb accumulator ready for the next step.

A controller pulses `start` with the chunk count, the starting accumulator and the key powers. It then offers chunks on a valid/ready handshake, with the lowest-addressed byte in bits [7:0]. When the last chunk has been absorbed, `done` pulses for one cycle and `h_out` holds the result. Clamping, computing the key powers, final reduction, adding s and producing the tag are left to the surrounding logic.

Top module: `poly4_accum`

## Requirements
- R1: Each 16-byte block, read as a little-endian 128-bit value B, is split into limbs B[25:0], B[51:26], B[77:52], B[103:78] and B[127:104] with bit 24 of the top limb set to 1, so the block value is B + 2^128.
- R2: One chunk maps the accumulator h to a value congruent, modulo 2^130-5, to (h + m1)·r^4 + m2·r^3 + m3·r^2 + m4·r. Here m1 is the block in msg_data[127:0] and m4 the block in msg_data[511:384].
- R3: The incoming accumulator is added to the first block of a chunk only, never to the other three.
- R4: A job with count N absorbs exactly N chunks in the order they are offered, applying R2 to each in turn.
- R5: With a count of zero, done pulses in the cycle after start and h_out equals h_in bit for bit.
- R6: When the input limbs are below 2^27, the result limbs 0, 2, 3 and 4 are below 2^26 and limb 1 is below 2^27 (32 bits stored per limb, limb i at h[32i+31:32i]).
- R7: msg_ready is high exactly while chunks remain. A chunk is taken only on a cycle where msg_valid and msg_ready are both high. Cycles without msg_valid leave the state unchanged, whatever msg_data carries.
- R8: done is a one-cycle pulse in the cycle after the last chunk is taken. h_out then holds its value until the next accepted start.
- R9: A start pulse while a job is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (taken only when idle) |
| chunk_cnt | input | CW | Number of 64-byte chunks in the job |
| h_in | input | 160 | Starting accumulator, five limbs of 32 bits |
| key_pow | input | 520 | Key powers: power p at bits [130(p-1)+129:130(p-1)], limb i at 26i within it |
| msg_valid | input | 1 | Chunk on msg_data is valid |
| msg_ready | output | 1 | Block accepts a chunk |
| msg_data | input | 512 | 64-byte chunk, byte k at bits [8k+7:8k] |
| h_out | output | 160 | Accumulator, five limbs of 32 bits |
| done | output | 1 | One-cycle pulse when the job completes |

## Verification
Setting the key to one reduces the result to h plus the four padded blocks. A wrong limb offset, a lost pad bit or an accumulator added to every block would therefore show up as a plain sum error. A key of zero, all-ones messages, keys near the modulus and an accumulator limb at 27 bits push the column sums and the wrap-by-five terms. A missing times-5 on any wrap product would break the modular match. Idle cycles with junk on msg_data and start pulses in mid-job check that the state and the done timing do not move. A count of zero catches a design that runs a chunk anyway or delays its done pulse.

// File: rtl/poly4_accum.sv
module poly4_accum #(
  parameter int LW = 26,
  parameter int HW = 32,
  parameter int CW = 8,
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     chunk_cnt,
  input  logic [5*HW-1:0]   h_in,
  input  logic [20*LW-1:0]  key_pow,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [511:0]      msg_data,
  output logic [5*HW-1:0]   h_out,
  output logic              done
);
  localparam int NB = 4;
  localparam int NL = 5;
  localparam int KW = NL * LW;
  localparam logic [DW-1:0] MASK = DW'((64'd1 << LW) - 1);

  logic [5*HW-1:0] h_reg, h_nxt;
  logic [CW-1:0]   left;
  logic            busy;

  logic [HW-1:0] hc [NB][NL];
  logic [DW-1:0] d  [NL];

  always_comb begin
    logic [HW-1:0]   raw;
    logic [LW-1:0]   k;
    logic [LW+2:0]   kl;
    logic [DW-1:0]   c0, c1, c2, c3, c4, t0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NL; i++) begin
        raw = msg_data[b*128 + i*24 +: 32] >> (2*i);
        if (i < NL-1) raw = raw & HW'(MASK);
        else          raw = raw | (HW'(1) << 24);
        if (b == 0) raw = raw + h_reg[i*HW +: HW];
        hc[b][i] = raw;
      end
    end
    for (int j = 0; j < NL; j++) begin
      d[j] = '0;
      for (int b = 0; b < NB; b++) begin
        for (int i = 0; i < NL; i++) begin
          if (i <= j) begin
            k  = key_pow[(NB-1-b)*KW + (j-i)*LW +: LW];
            kl = (LW+3)'(k);
          end else begin
            k  = key_pow[(NB-1-b)*KW + (j-i+NL)*LW +: LW];
            kl = ((LW+3)'(k) << 2) + (LW+3)'(k);
          end
          d[j] = d[j] + DW'(hc[b][i]) * DW'(kl);
        end
      end
    end
    c0 = d[0];
    c1 = d[1] + (c0 >> LW);
    c2 = d[2] + (c1 >> LW);
    c3 = d[3] + (c2 >> LW);
    c4 = d[4] + (c3 >> LW);
    t0 = (c0 & MASK) + (c4 >> LW) * 5;
    h_nxt = {HW'(c4 & MASK), HW'(c3 & MASK), HW'(c2 & MASK),
             HW'((c1 & MASK) + (t0 >> LW)), HW'(t0 & MASK)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_reg <= '0;
      left  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        h_reg <= h_in;
        left  <= chunk_cnt;
        if (chunk_cnt == '0) done <= 1'b1;
        else                 busy <= 1'b1;
      end else if (busy && msg_valid) begin
        h_reg <= h_nxt;
        left  <= left - 1'b1;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign msg_ready = busy;
  assign h_out     = h_reg;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_ready && start && chunk_cnt == '0) |=> (done && h_out == $past(h_in)));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && !msg_valid) |=> ($stable(h_out) && msg_ready && !done));
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && start && !msg_valid) |=> $stable(h_out));
  a_r7_ready_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !msg_ready);
  a_r6_limb_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(msg_ready) && $past(h_in[HW+LW+1 +: HW-LW-1]) == '0)
      |-> (h_out[0 +: HW] < (1 << LW) && h_out[HW +: HW] < (1 << (LW+1)) &&
           h_out[2*HW +: HW] < (1 << LW) && h_out[3*HW +: HW] < (1 << LW) &&
           h_out[4*HW +: HW] < (1 << LW)));
endmodule

// File: tb/tb_poly4_accum.sv
module tb_poly4_accum;
  localparam logic [263:0] P = (264'd1 << 130) - 264'd5;

  logic clk = 0, rst_n = 0, start = 0, msg_valid = 0;
  logic [7:0] chunk_cnt = 0;
  logic [159:0] h_in = 0;
  logic [519:0] key_pow = 0;
  logic [511:0] msg_data = 0;
  logic msg_ready, done;
  logic [159:0] h_out;
  int checks = 0, fails = 0;
  logic [511:0] ch [0:7];

  always #2.5 clk = ~clk;

  poly4_accum dut (.clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt),
    .h_in(h_in), .key_pow(key_pow), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .h_out(h_out), .done(done));

  function automatic logic [263:0] red(input logic [263:0] x);
    for (int n = 0; n < 4; n++) x = {134'd0, x[129:0]} + (x >> 130) * 264'd5;
    while (x >= P) x = x - P;
    return x;
  endfunction

  function automatic logic [263:0] mulm(input logic [263:0] a, input logic [263:0] b);
    return red(red(a) * red(b));
  endfunction

  function automatic logic [263:0] limbval(input logic [159:0] h);
    logic [263:0] v = 0;
    for (int i = 0; i < 5; i++) v = v + ({232'd0, h[i*32 +: 32]} << (26*i));
    return red(v);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [263:0] act, input logic [263:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_job(input logic [129:0] r, input logic [159:0] hin, input int cnt,
                         input int gap, input bit poke);
    logic [263:0] rp [1:4];
    logic [263:0] hv, m [4];
    logic [159:0] held;
    rp[1] = red({134'd0, r});
    for (int p = 2; p <= 4; p++) rp[p] = mulm(rp[p-1], rp[1]);
    for (int p = 1; p <= 4; p++)
      for (int i = 0; i < 5; i++) key_pow[(p-1)*130 + i*26 +: 26] = rp[p][i*26 +: 26];
    hv = limbval(hin);
    for (int c = 0; c < cnt; c++) begin
      for (int b = 0; b < 4; b++) m[b] = {136'd0, ch[c][b*128 +: 128]} + (264'd1 << 128);
      hv = red(mulm(hv + m[0], rp[4]) + mulm(m[1], rp[3]) + mulm(m[2], rp[2]) + mulm(m[3], rp[1]));
    end
    @(negedge clk);
    start = 1; chunk_cnt = 8'(cnt); h_in = hin;
    @(negedge clk);
    start = 0; h_in = ~hin;
    if (cnt == 0) begin
      chk(done == 1'b1, "R5 done after start", 264'(done), 264'd1);
      chk(h_out == hin, "R5 passthrough", 264'(h_out), 264'(hin));
    end else begin
      for (int c = 0; c < cnt; c++) begin
        for (int g = 0; g < gap; g++) begin
          msg_valid = 0; msg_data = {16{$urandom}};
          if (poke) begin start = 1; chunk_cnt = 0; end
          @(negedge clk);
          start = 0;
          chk(done == 1'b0, "R9 R7 no done while busy", 264'(done), 264'd0);
        end
        chk(msg_ready == 1'b1, "R7 ready while chunks remain", 264'(msg_ready), 264'd1);
        msg_valid = 1; msg_data = ch[c];
        @(negedge clk);
        msg_valid = 0;
        chk(done == (c == cnt-1), "R8 done timing", 264'(done), 264'(c == cnt-1));
      end
      chk(limbval(h_out) == hv, "R2 R4 accumulator value", limbval(h_out), hv);
      chk(msg_ready == 1'b0, "R7 ready low after job", 264'(msg_ready), 264'd0);
      chk(h_out[31:0] < 32'h400_0000 && h_out[63:32] < 32'h800_0000 &&
          h_out[95:64] < 32'h400_0000 && h_out[127:96] < 32'h400_0000 &&
          h_out[159:128] < 32'h400_0000, "R6 limb bounds", 264'(h_out), 264'd0);
    end
    held = h_out;
    msg_valid = 1; msg_data = {16{$urandom}};
    @(negedge clk);
    msg_valid = 0;
    chk(done == 1'b0, "R8 single-cycle done", 264'(done), 264'd0);
    chk(h_out == held, "R8 R7 hold after done", 264'(h_out), 264'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [129:0] r;
    logic [159:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && msg_ready == 0 && h_out == 0, "reset state", 264'(h_out), 264'd0);

    // R1 R3: unit key, result is h + m1 + m2 + m3 + m4
    for (int k = 0; k < 64; k++) ch[0][k*8 +: 8] = 8'(k * 7 + 1);
    h = {32'h3FF_FFFF, 32'h2AB_CDEF, 32'h155_5555, 32'h7FF_FFFF, 32'h3FF_FFFF};
    run_job(130'd1, h, 1, 0, 0);
    // R1: all-zero message, unit key, zero h: 4 pad bits only
    ch[0] = '0;
    run_job(130'd1, 160'd0, 1, 1, 0);
    // R5: zero count
    run_job(130'h12345, h, 0, 0, 0);
    // zero key gives zero
    ch[0] = {16{32'hDEADBEEF}};
    run_job(130'd0, h, 1, 0, 0);
    // all-ones messages, key just below the modulus
    for (int c = 0; c < 3; c++) ch[c] = '1;
    run_job(130'(P - 264'd1), h, 3, 0, 0);
    // R9: start pulses mid-job with idle gaps
    for (int c = 0; c < 2; c++) ch[c] = {16{$urandom}};
    run_job(130'h0FFF_FFFC_0FFF_FFFC_0FFF_FFFC_0FFF_FFFF, h, 2, 2, 1);
    // sweep of keys, counts and messages
    for (int s = 0; s < 8; s++) begin
      for (int n = 1; n <= 4; n++) begin
        r = {2'($urandom), $urandom, $urandom, $urandom, $urandom};
        for (int c = 0; c < n; c++) ch[c] = {16{$urandom}};
        for (int i = 0; i < 5; i++) h[i*32 +: 32] = 32'($urandom % 32'h800_0000);
        run_job(r, h, n, (s + n) % 3, 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule